// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write traffic of a parallel NOR-style flash bus inside a synchronous clock domain. Each write arrives as a single-clock strobe with an address and a data word. The decoder follows the two-cycle unlock prefix, the optional second prefix used by the erase family, and the cycle that chooses the operation. When a command is recognised, it issues a one-cycle strobe that carries a command code, the address and data of the cycle that completed the command, and the plane select bits.

The decoder also holds two mode flags. The bypass flag is sticky: once it is set, every write becomes a program of its own address and data, and only reset clears the flag. The identifier flag tells the read path to return identification data instead of array contents. A busy input from the program engine blocks all decoding while an embedded program is running. The array, program and erase timing, and any high-voltage behaviour belong to other blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is held and after it is released, `cmd_valid_o`, `bypass_o` and `id_mode_o` are 0 and the tracker is idle. A reset during bypass mode brings back normal decoding, so a later 0xB0 write decodes as a suspend.
- R2: The write sequence 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 followed by any address/data gives `cmd_o`=1 (program), with the address and data of the fourth write, one clock after that write.
- R3: Only address bits 15..0 and data bits 7..0 are compared. A prefix whose address bits 19..16 and data bits 15..8 are nonzero is still accepted.
- R4: After 0x5555/0x80 and a second prefix, the sixth write selects the command. 0x5555/0x10 gives chip erase (`cmd_o`=2). Any address with 0x30 gives sector erase (3). Any address with 0x40 gives sector lockout (4). The strobe carries the sixth write's address.
- R5: The sixth-write form 0x5555/0xA0 gives bypass entry (5) and sets `bypass_o`. After that, every write gives a program (1), including writes of 0xB0, 0x30 and 0x10.
- R6: A single write of 0xB0 at any address gives erase suspend (6). A single write of 0x30 gives erase resume (7), and `plane_o` equals address bits 19..18 of that write.
- R7: Prefix then 0x5555/0x90 gives ID entry (8) and sets `id_mode_o`. ID exit (9) clears `id_mode_o` and is accepted as prefix then 0x5555/0xF0, or as a single 0xF0 write at any address.
- R8: A write made while `busy_i` is 1 produces no strobe and leaves the tracker where it was, so the next unblocked write continues the sequence.
- R9: A write that does not match the expected step sends the tracker to idle. The same write is then decoded again as a first prefix cycle or as a single-cycle command.
- R10: Each recognised command gives exactly one `cmd_valid_o` cycle. Prefix writes and unmatched writes give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Single-cycle write strobe |
| wr_addr_i | input | ADDR_W | Address of the write |
| wr_data_i | input | DATA_W | Data of the write |
| busy_i | input | 1 | Embedded program running; writes are ignored |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_o | output | 4 | Command code (see R2 to R7) |
| cmd_addr_o | output | ADDR_W | Address latched from the completing write |
| cmd_data_o | output | DATA_W | Data latched from the completing write |
| plane_o | output | 2 | Top two address bits of the completing write |
| bypass_o | output | 1 | Sticky single-write program mode |
| id_mode_o | output | 1 | Reads go to the identifier |

## Verification
A wrong tracker state shows up only at the next write that completes a sequence. That write then gives either a missing strobe or a wrong code one clock later. Sequences are therefore written back to back, so that a stale step fails at the following command. The re-decode of mismatched writes, the busy freeze and the sticky bypass are each followed straight away by a write whose decode depends on the state the previous write left behind. This makes each of these errors visible within one or two writes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_NONE       = 4'd0,
    CMD_PROG       = 4'd1,
    CMD_CHIP_ERASE = 4'd2,
    CMD_SECT_ERASE = 4'd3,
    CMD_SECT_LOCK  = 4'd4,
    CMD_BYPASS     = 4'd5,
    CMD_SUSPEND    = 4'd6,
    CMD_RESUME     = 4'd7,
    CMD_ID_ENTER   = 4'd8,
    CMD_ID_EXIT    = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLK1,
    ST_UNLK2,
    ST_PROG_ARM,
    ST_ERS3,
    ST_ERS4,
    ST_ERS5
  } seq_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_ID_ON   = 8'h90;
  localparam logic [7:0] OP_ID_OFF  = 8'hF0;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_SECT    = 8'h30;
  localparam logic [7:0] OP_LOCK    = 8'h40;
  localparam logic [7:0] OP_SUSP    = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'h30;

endpackage

// File: rtl/cmd_cycle_match.sv
module cmd_cycle_match #(
  parameter int CMP_W = 16,
  parameter int CODE_W = 8,
  parameter logic [CMP_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [CMP_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic [CMP_W-1:0]  addr_i,
  input  logic [CODE_W-1:0] data_i,
  output logic              hit_a_o,
  output logic              hit_b_o,
  output logic [CODE_W-1:0] code_o
);
  assign hit_a_o = (addr_i == KEY_ADDR_A);
  assign hit_b_o = (addr_i == KEY_ADDR_B);
  assign code_o  = data_i;
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              busy_i,
  input  logic              bypass_i,
  input  logic              hit_a_i,
  input  logic              hit_b_i,
  input  logic [7:0]        code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output cmd_e              cmd_nxt_o,
  output logic              cmd_valid_o,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  seq_e st_q, st_nxt;
  cmd_e cmd_nxt;
  logic restart;

  always_comb begin
    st_nxt  = st_q;
    cmd_nxt = CMD_NONE;
    restart = 1'b0;
    if (wr_i && !busy_i) begin
      case (st_q)
        ST_IDLE: restart = 1'b1;
        ST_UNLK1: begin
          if (hit_b_i && code_i == KEY_SECOND) st_nxt = ST_UNLK2;
          else restart = 1'b1;
        end
        ST_UNLK2: begin
          if (hit_a_i && code_i == OP_PROG) st_nxt = ST_PROG_ARM;
          else if (hit_a_i && code_i == OP_ERASE) st_nxt = ST_ERS3;
          else if (hit_a_i && code_i == OP_ID_ON) begin
            st_nxt  = ST_IDLE;
            cmd_nxt = CMD_ID_ENTER;
          end else if (hit_a_i && code_i == OP_ID_OFF) begin
            st_nxt  = ST_IDLE;
            cmd_nxt = CMD_ID_EXIT;
          end else restart = 1'b1;
        end
        ST_PROG_ARM: begin
          st_nxt  = ST_IDLE;
          cmd_nxt = CMD_PROG;
        end
        ST_ERS3: begin
          if (hit_a_i && code_i == KEY_FIRST) st_nxt = ST_ERS4;
          else restart = 1'b1;
        end
        ST_ERS4: begin
          if (hit_b_i && code_i == KEY_SECOND) st_nxt = ST_ERS5;
          else restart = 1'b1;
        end
        ST_ERS5: begin
          st_nxt = ST_IDLE;
          if (hit_a_i && code_i == OP_CHIP) cmd_nxt = CMD_CHIP_ERASE;
          else if (code_i == OP_SECT) cmd_nxt = CMD_SECT_ERASE;
          else if (code_i == OP_LOCK) cmd_nxt = CMD_SECT_LOCK;
          else if (hit_a_i && code_i == OP_PROG) cmd_nxt = CMD_BYPASS;
          else restart = 1'b1;
        end
        default: st_nxt = ST_IDLE;
      endcase
      // mismatched or idle-step write: decode again from idle
      if (restart) begin
        st_nxt = ST_IDLE;
        if (bypass_i) cmd_nxt = CMD_PROG;
        else if (code_i == OP_SUSP) cmd_nxt = CMD_SUSPEND;
        else if (code_i == OP_RESUME) cmd_nxt = CMD_RESUME;
        else if (code_i == OP_ID_OFF) cmd_nxt = CMD_ID_EXIT;
        else if (hit_a_i && code_i == KEY_FIRST) st_nxt = ST_UNLK1;
      end
    end
  end

  assign cmd_nxt_o = cmd_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cmd_valid_o <= 1'b0;
      cmd_o       <= CMD_NONE;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      st_q        <= st_nxt;
      cmd_valid_o <= (cmd_nxt != CMD_NONE);
      cmd_o       <= cmd_nxt;
      if (cmd_nxt != CMD_NONE) begin
        cmd_addr_o <= addr_i;
        cmd_data_o <= data_i;
      end
    end
  end

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(wr_i && !busy_i)); // R8
  AST_BYPASS_PROG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && $past(bypass_i)) |-> (cmd_o == CMD_PROG)); // R5
  AST_BYPASS_TRACKER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> (st_q == ST_IDLE)); // R5
  AST_PREFIX_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_UNLK1, ST_UNLK2, ST_ERS3, ST_ERS4}) |-> !cmd_valid_o); // R10

endmodule

// File: rtl/cmd_mode_regs.sv
module cmd_mode_regs
  import flash_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_nxt_i,
  output logic bypass_o,
  output logic id_mode_o
);
  logic bypass_q, id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_q <= 1'b0;
      id_q     <= 1'b0;
    end else begin
      if (cmd_nxt_i == CMD_BYPASS) bypass_q <= 1'b1;
      if (cmd_nxt_i == CMD_ID_ENTER) id_q <= 1'b1;
      else if (cmd_nxt_i == CMD_ID_EXIT) id_q <= 1'b0;
    end
  end

  assign bypass_o  = bypass_q;
  assign id_mode_o = id_q;

  AST_BYPASS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bypass_q) |-> bypass_q); // R5
  AST_ID_EXIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_nxt_i == CMD_ID_EXIT) |-> !id_q); // R7

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CMP_W = 16,
  parameter logic [CMP_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [CMP_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [1:0]        plane_o,
  output logic              bypass_o,
  output logic              id_mode_o
);
  localparam int CODE_W = 8;
  localparam int PLANE_LSB = ADDR_W - 2;

  logic              hit_a, hit_b;
  logic [CODE_W-1:0] code;
  cmd_e              cmd_nxt, cmd_q;

  cmd_cycle_match #(
    .CMP_W(CMP_W), .CODE_W(CODE_W),
    .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
  ) u_match (
    .addr_i (wr_addr_i[CMP_W-1:0]),
    .data_i (wr_data_i[CODE_W-1:0]),
    .hit_a_o(hit_a),
    .hit_b_o(hit_b),
    .code_o (code)
  );

  cmd_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .busy_i     (busy_i),
    .bypass_i   (bypass_o),
    .hit_a_i    (hit_a),
    .hit_b_i    (hit_b),
    .code_i     (code),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .cmd_nxt_o  (cmd_nxt),
    .cmd_valid_o(cmd_valid_o),
    .cmd_o      (cmd_q),
    .cmd_addr_o (cmd_addr_o),
    .cmd_data_o (cmd_data_o)
  );

  cmd_mode_regs u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_nxt_i(cmd_nxt),
    .bypass_o (bypass_o),
    .id_mode_o(id_mode_o)
  );

  assign cmd_o   = cmd_q;
  assign plane_o = cmd_addr_o[ADDR_W-1:PLANE_LSB];

  AST_ID_ENTER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_q == CMD_ID_ENTER) |-> id_mode_o); // R7
  AST_BYPASS_ENTER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_q == CMD_BYPASS) |-> bypass_o); // R5

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] data = '0;
  logic        busy = 1'b0;
  logic        cmd_valid;
  logic [3:0]  cmd;
  logic [19:0] cmd_addr;
  logic [15:0] cmd_data;
  logic [1:0]  plane;
  logic        bypass, id_mode;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .wr_addr_i(addr), .wr_data_i(data),
    .busy_i(busy), .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_addr_o(cmd_addr),
    .cmd_data_o(cmd_data), .plane_o(plane), .bypass_o(bypass), .id_mode_o(id_mode)
  );

  typedef struct packed {
    logic [19:0] a;
    logic [15:0] d;
    logic        b;
    logic        v;
    logic [3:0]  c;
    logic        id;
    logic        byp;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t TBL [NV] = '{
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R2 program
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h00A0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h12345, 16'hBEEF, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0},
    '{20'hF5555, 16'hABAA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R3 upper bits
    '{20'h32AAA, 16'hFF55, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h00A0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h00400, 16'h0001, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R4 chip erase
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h0080, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h0010, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R4 sector erase
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h0080, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h4A000, 16'h0030, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R4 lockout
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h0080, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h0C123, 16'h0040, 1'b0, 1'b1, 4'd4, 1'b0, 1'b0},
    '{20'h07777, 16'h00B0, 1'b0, 1'b1, 4'd6, 1'b0, 1'b0}, // R6 suspend
    '{20'hC0010, 16'h0030, 1'b0, 1'b1, 4'd7, 1'b0, 1'b0}, // R6 resume plane 3
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R7 id entry
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h0090, 1'b0, 1'b1, 4'd8, 1'b1, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0}, // R7 long exit
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0},
    '{20'h05555, 16'h00F0, 1'b0, 1'b1, 4'd9, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h0090, 1'b0, 1'b1, 4'd8, 1'b1, 1'b0},
    '{20'h01234, 16'h00F0, 1'b0, 1'b1, 4'd9, 1'b0, 1'b0}, // R7 short exit
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R9 restart on AA
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h00A0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h00010, 16'h5A5A, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R9 suspend mid-sequence
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h0080, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h01000, 16'h00B0, 1'b0, 1'b1, 4'd6, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R9 resume after one key
    '{20'h01111, 16'h0030, 1'b0, 1'b1, 4'd7, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R8 busy freezes tracker
    '{20'h02AAA, 16'h0055, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h00A0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h00020, 16'h0007, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h00020, 16'h0007, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, // R5 bypass entry
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h0080, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h00AA, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h02AAA, 16'h0055, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    '{20'h05555, 16'h00A0, 1'b0, 1'b1, 4'd5, 1'b0, 1'b1},
    '{20'h0ABCD, 16'h00B0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1}, // R5 codes become data
    '{20'h80000, 16'h0030, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1},
    '{20'h03333, 16'h0010, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_cycle(input logic [19:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    wr = 1'b1; addr = a; data = d; busy = b;
    @(negedge clk);
    wr = 1'b0; busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!cmd_valid && !bypass && !id_mode, "R1", "reset outputs",
        {61'd0, cmd_valid, bypass, id_mode}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !bypass && !id_mode, "R1", "after release",
        {61'd0, cmd_valid, bypass, id_mode}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      logic ok;
      t = TBL[i];
      write_cycle(t.a, t.d, t.b);
      ok = (cmd_valid == t.v) && (id_mode == t.id) && (bypass == t.byp);
      if (t.v) begin
        ok = ok && (cmd == t.c) && (cmd_addr == t.a) && (cmd_data == t.d);
        if (t.c == 4'd7) ok = ok && (plane == t.a[19:18]);
      end
      chk(ok, $sformatf("R%0d-row%0d", (i < 4) ? 2 : (i < 8) ? 3 : (i < 26) ? 4 :
                        (i < 28) ? 6 : (i < 38) ? 7 : (i < 49) ? 9 : (i < 55) ? 8 : 5, i),
          "v/cmd/addr/data/plane/id/byp",
          {cmd_valid, cmd, cmd_addr, cmd_data, plane, id_mode, bypass, 19'd0},
          {t.v, t.c, t.a, t.d, t.a[19:18], t.id, t.byp, 19'd0});
    end

    // R10 strobe lasts one cycle
    @(negedge clk);
    chk(!cmd_valid, "R10", "strobe width", {63'd0, cmd_valid}, 64'd0);

    // R8 busy write in bypass mode gives nothing
    write_cycle(20'h00055, 16'h1234, 1'b1);
    chk(!cmd_valid && bypass, "R8", "busy in bypass", {62'd0, cmd_valid, bypass}, 64'd1);

    // R1 reset clears bypass mode
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(!cmd_valid && !bypass && !id_mode, "R1", "reset in bypass",
        {61'd0, cmd_valid, bypass, id_mode}, 64'd0);
    rst_ni = 1'b1;
    write_cycle(20'h00ABC, 16'h00B0, 1'b0);
    chk(cmd_valid && cmd == 4'd6 && !bypass, "R1", "normal decode after reset",
        {59'd0, cmd_valid, cmd}, {59'd0, 1'b1, 4'd6});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule